// File: doc/BRIEF.md
# Two-Stage Pipeline Hazard Detector

This block decides, every cycle, whether the first stage of a two-stage in-order pipeline must hold its instruction or discard it. The first stage fetches, decodes, reads registers, computes in the ALU and works out the next PC. The second stage accesses data memory and writes the register file. The block looks at what currently sits in each stage and drives two signals back to the first stage: a stall, which freezes the first stage and the PC while the second stage drains, and a flush, which turns the first-stage instruction into a bubble.

A data hazard arises when the second-stage instruction will write a register that the first-stage instruction reads. The `POLICY` parameter selects how this is detected. The conservative policy holds stage one whenever stage two contains a real instruction. The precise policy holds only on a destination/source register match. A control hazard arises when a resolved redirect names a target other than the PC the first stage actually fetched. In that case the fetched instruction is wrong, and delaying it would not fix it, so it is flushed. When the fetch already went the right way, nothing is flushed.

The block has no state. Both outputs are pure functions of the present inputs. Forwarding, the register file and the memories live elsewhere.

Top module: `hazard_unit`

## Requirements
- R1: With `POLICY` precise, `st1_stall` is 1 when `ex2_live` and `ex2_wr_en` are both 1 and `ex2_dst` equals a used stage-one source number. Source i occupies bits [i*RW +: RW] of `st1_src_num`, and its use flag is bit i of `st1_src_use`. Either source may produce the match.
- R2: With `POLICY` precise, a live stage-two instruction with `ex2_wr_en` = 0 (for example a store) never produces `st1_stall`, even if its `ex2_dst` equals a used source.
- R3: With `POLICY` precise, a live stage-two writer whose destination differs from every used stage-one source produces no `st1_stall`.
- R4: A source whose use flag is 0 never contributes to a register match, even if its number equals `ex2_dst`.
- R5: With `POLICY` conservative, `st1_stall` is 1 whenever `ex2_live` is 1 and no flush is requested, whatever the write enable and register numbers are.
- R6: When `ex2_live` is 0 (a NOP or bubble in stage two), `st1_stall` is 0 under both policies. This guarantees that a stall always ends after one cycle.
- R7: `st1_flush` is 1 when `redir_valid` is 1 and `redir_target` differs from `st1_pc`.
- R8: `st1_flush` is 0 when `redir_valid` is 0, and also when `redir_target` equals `st1_pc`, because the fetch already took the correct path.
- R9: Flush has priority over stall: `st1_stall` is 0 in any cycle in which `st1_flush` is 1.
- R10: Both outputs respond in the same cycle as the inputs that cause them, with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex2_live | input | 1 | Stage two holds a real instruction (0 = NOP/bubble) |
| ex2_wr_en | input | 1 | Stage-two instruction writes a register |
| ex2_dst | input | RW | Stage-two destination register number |
| st1_src_num | input | NSRC*RW | Stage-one source register numbers, source i at [i*RW +: RW] |
| st1_src_use | input | NSRC | Stage-one source use flags, bit i for source i |
| redir_valid | input | 1 | A resolved redirect is present this cycle |
| redir_target | input | PC_W | Resolved next-fetch address |
| st1_pc | input | PC_W | Address of the instruction held in stage one |
| st1_stall | output | 1 | Hold stage one and the PC |
| st1_flush | output | 1 | Replace the stage-one instruction by a bubble |

## Verification
The bench builds two copies of the block, both with RW = 5, NSRC = 2 and PC_W = 32. One copy uses the precise policy and the other the conservative one, and every input pattern is applied to both at the same time. Because both copies see identical stimulus, a single pattern can show the contrast between the policies: a live non-writer, or a writer with no register match, holds the conservative copy but not the precise one. The 5-bit register numbers make the top register, 31, reachable as a boundary for matches on the second source.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic {
        POL_CONSERVATIVE = 1'b0,
        POL_PRECISE      = 1'b1
    } stall_policy_e;

    typedef struct packed {
        logic stall;
        logic flush;
    } hzd_req_t;

    function automatic logic gated_hit(input logic used, input logic equal);
        return used & equal;
    endfunction

endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
    parameter int RW   = 5,
    parameter int NSRC = 2
) (
    input  logic [RW-1:0]      dst,
    input  logic [NSRC*RW-1:0] src_num,
    input  logic [NSRC-1:0]    src_use,
    output logic               any_hit
);
    logic [NSRC-1:0] hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign hit[i] = hzd_pkg::gated_hit(src_use[i], src_num[i*RW +: RW] == dst);
    end

    assign any_hit = |hit;

    always_comb begin
        // R4
        unused_src_chk: assert (!(any_hit && ((src_use & hit) == '0)))
            else $error("match raised without a used source");
    end
endmodule

// File: rtl/hzd_data_stall.sv
module hzd_data_stall #(
    parameter hzd_pkg::stall_policy_e POLICY = hzd_pkg::POL_PRECISE
) (
    input  logic live,
    input  logic wr_en,
    input  logic reg_hit,
    output logic want_stall
);
    logic precise_stall;

    assign precise_stall = live & wr_en & reg_hit;
    assign want_stall    = (POLICY == hzd_pkg::POL_PRECISE) ? precise_stall : live;

    always_comb begin
        // R2
        if (POLICY == hzd_pkg::POL_PRECISE && !wr_en)
            store_no_stall_chk: assert (!want_stall)
                else $error("non-writer requested a stall");
    end
endmodule

// File: rtl/hzd_ctrl_flush.sv
module hzd_ctrl_flush #(
    parameter int PC_W = 32
) (
    input  logic            redir_valid,
    input  logic [PC_W-1:0] redir_target,
    input  logic [PC_W-1:0] fetched_pc,
    output logic            want_flush
);
    logic wrong_path;

    assign wrong_path = (redir_target != fetched_pc);
    assign want_flush = redir_valid & wrong_path;
endmodule

// File: rtl/hazard_unit.sv
module hazard_unit #(
    parameter int                     RW     = 5,
    parameter int                     NSRC   = 2,
    parameter int                     PC_W   = 32,
    parameter hzd_pkg::stall_policy_e POLICY = hzd_pkg::POL_PRECISE
) (
    input  logic               ex2_live,
    input  logic               ex2_wr_en,
    input  logic [RW-1:0]      ex2_dst,
    input  logic [NSRC*RW-1:0] st1_src_num,
    input  logic [NSRC-1:0]    st1_src_use,
    input  logic               redir_valid,
    input  logic [PC_W-1:0]    redir_target,
    input  logic [PC_W-1:0]    st1_pc,
    output logic               st1_stall,
    output logic               st1_flush
);
    localparam int SRC_BITS = NSRC * RW;

    logic             reg_hit;
    logic             want_stall;
    logic             want_flush;
    hzd_pkg::hzd_req_t req;

    hzd_src_match #(.RW(RW), .NSRC(NSRC)) u_match (
        .dst     (ex2_dst),
        .src_num (st1_src_num[SRC_BITS-1:0]),
        .src_use (st1_src_use),
        .any_hit (reg_hit)
    );

    hzd_data_stall #(.POLICY(POLICY)) u_data (
        .live       (ex2_live),
        .wr_en      (ex2_wr_en),
        .reg_hit    (reg_hit),
        .want_stall (want_stall)
    );

    hzd_ctrl_flush #(.PC_W(PC_W)) u_ctrl (
        .redir_valid  (redir_valid),
        .redir_target (redir_target),
        .fetched_pc   (st1_pc),
        .want_flush   (want_flush)
    );

    always_comb begin
        req.flush = want_flush;
        req.stall = want_stall & ~want_flush;
    end

    assign st1_stall = req.stall;
    assign st1_flush = req.flush;

    always_comb begin
        // R9
        flush_over_stall_chk: assert (!(st1_stall && st1_flush))
            else $error("stall and flush together");
        // R6
        if (!ex2_live)
            bubble_no_stall_chk: assert (!st1_stall)
                else $error("stall behind a bubble");
        // R8
        if (!redir_valid)
            no_redir_no_flush_chk: assert (!st1_flush)
                else $error("flush without redirect");
        // R5
        if (POLICY == hzd_pkg::POL_CONSERVATIVE && ex2_live && !st1_flush)
            cons_live_stall_chk: assert (st1_stall)
                else $error("conservative policy missed a stall");
    end
endmodule

// File: tb/tb_hazard_unit.sv
module tb_hazard_unit;
    localparam int RW = 5, NSRC = 2, PC_W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic               ex2_live = 0, ex2_wr_en = 0;
    logic [RW-1:0]      ex2_dst = '0;
    logic [NSRC*RW-1:0] st1_src_num = '0;
    logic [NSRC-1:0]    st1_src_use = '0;
    logic               redir_valid = 0;
    logic [PC_W-1:0]    redir_target = '0, st1_pc = '0;
    logic               stall_p, flush_p, stall_c, flush_c;

    hazard_unit #(.RW(RW), .NSRC(NSRC), .PC_W(PC_W), .POLICY(hzd_pkg::POL_PRECISE)) dut (
        .ex2_live(ex2_live), .ex2_wr_en(ex2_wr_en), .ex2_dst(ex2_dst),
        .st1_src_num(st1_src_num), .st1_src_use(st1_src_use),
        .redir_valid(redir_valid), .redir_target(redir_target), .st1_pc(st1_pc),
        .st1_stall(stall_p), .st1_flush(flush_p));

    hazard_unit #(.RW(RW), .NSRC(NSRC), .PC_W(PC_W), .POLICY(hzd_pkg::POL_CONSERVATIVE)) dut_cons (
        .ex2_live(ex2_live), .ex2_wr_en(ex2_wr_en), .ex2_dst(ex2_dst),
        .st1_src_num(st1_src_num), .st1_src_use(st1_src_use),
        .redir_valid(redir_valid), .redir_target(redir_target), .st1_pc(st1_pc),
        .st1_stall(stall_c), .st1_flush(flush_c));

    typedef struct {
        logic  sp, fp, sc, fc;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    task automatic check(input logic act, input logic exp, input string what, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic live, input logic wr, input int dst,
                         input int s0, input logic u0, input int s1, input logic u1,
                         input logic rv, input int tgt, input int pc,
                         input logic sp, input logic fp, input logic sc, input logic fc,
                         input string tag);
        exp_t e;
        @(posedge clk);
        ex2_live     = live;
        ex2_wr_en    = wr;
        ex2_dst      = RW'(dst);
        st1_src_num  = {RW'(s1), RW'(s0)};
        st1_src_use  = {u1, u0};
        redir_valid  = rv;
        redir_target = PC_W'(tgt);
        st1_pc       = PC_W'(pc);
        e.sp = sp; e.fp = fp; e.sc = sc; e.fc = fc; e.tag = tag;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(stall_p, e.sp, "precise stall", e.tag);
            check(flush_p, e.fp, "precise flush", e.tag);
            check(stall_c, e.sc, "conservative stall", e.tag);
            check(flush_c, e.fc, "conservative flush", e.tag);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state after reset: nothing requested
        apply(0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0, "R6 idle");
        // R1 match on source 0, and R10 same-cycle response
        apply(1,1,3, 3,1, 7,1, 0,0,'h40,    1,0,1,0, "R1 src0");
        // R1 match on source 1
        apply(1,1,9, 2,1, 9,1, 0,0,'h40,    1,0,1,0, "R1 src1");
        // R2 store: writer disabled, number matches; R5 conservative still holds
        apply(1,0,3, 3,1, 3,1, 0,0,'h40,    0,0,1,0, "R2 R5 store");
        // R3 writer with no match
        apply(1,1,4, 5,1, 6,1, 0,0,'h40,    0,0,1,0, "R3 mismatch");
        // R4 matching numbers on unused sources
        apply(1,1,8, 8,0, 8,0, 0,0,'h40,    0,0,1,0, "R4 unused");
        // R4 one unused match, other used mismatch
        apply(1,1,8, 8,0, 1,1, 0,0,'h40,    0,0,1,0, "R4 mixed");
        // R6 bubble with matching writer fields
        apply(0,1,3, 3,1, 3,1, 0,0,'h40,    0,0,0,0, "R6 bubble");
        // R7 wrong path flush, R9 overrides a matching stall
        apply(1,1,3, 3,1, 0,0, 1,'h100,'h44, 0,1,0,1, "R7 R9 redirect");
        // R7 flush with bubble in stage two
        apply(0,0,0, 0,0, 0,0, 1,'h80,'h84, 0,1,0,1, "R7 bubble");
        // R8 correct path: no flush, data stall stays
        apply(1,1,3, 3,1, 0,0, 1,'h44,'h44, 1,0,1,0, "R8 right path");
        // R8 differing target but no redirect
        apply(0,0,0, 0,0, 0,0, 0,'h100,'h44, 0,0,0,0, "R8 no redirect");
        // R1 top register on source 1
        apply(1,1,31, 30,1, 31,1, 0,0,0,    1,0,1,0, "R1 reg31");
        // R3 top register versus 30 on both sources
        apply(1,1,31, 30,1, 30,1, 0,0,0,    0,0,1,0, "R3 reg31");
        @(posedge clk);
        @(posedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule